// File: doc/BRIEF.md
# Programmable Millisecond Periodic Timer

This block gives a host driver a hardware time base for its periodic housekeeping. Software programs a count of milliseconds and chooses between a single expiry and a repeating one. It then starts the timer by writing a self-clearing start bit. A prescaler divides the core clock down to a one-millisecond tick, and a down-counter measures the programmed number of ticks. At expiry the counter either reloads and runs on, or it halts.

Each expiry sets a sticky bit in a small interrupt-cause register. The driver reads that register later, when its ordinary interrupt handling runs, and clears the bit by writing a 1 to it. A separate enable bit lets software switch the timer interrupt off completely. The register port is a plain single-cycle write port with a registered read port.

Top module: `ms_period_timer`

## Requirements
- R1: After reset, `irq_o` is 0, every register reads 0, and no expiry occurs until the timer is started.
- R2: Writing address 0 with bit 0 set (start) loads the counter from the duration register (address 1) and restarts the prescaler phase. Bit 0 is not stored and always reads back as 0. Bit 1 (loop) and bit 2 (interrupt enable) are stored and read back.
- R3: While running, the prescaler gives one tick every `CYC_PER_MS` clock cycles. For a duration D ≥ 1, the cause bit becomes visible exactly D·`CYC_PER_MS` cycles after the clock edge that accepted the start write.
- R4: An expiry sets bit 0 of the cause register (address 2), and the bit stays set until software clears it.
- R5: With loop = 0, the timer stops after its expiry and raises no further cause.
- R6: With loop = 1, the counter reloads the duration at each expiry and expires again every D milliseconds. If loop is cleared while the timer runs, the timer stops after its next expiry.
- R7: With interrupt enable = 0, an expiry does not set the cause bit. Setting the enable afterwards does not bring back the missed expiry.
- R8: `irq_o` is a registered copy of (cause bit AND interrupt enable). Clearing the enable drops `irq_o` on the next edge but leaves the cause bit set.
- R9: A duration of 0 expires on the first tick after the start. In loop mode it then expires on every tick.
- R10: A start write while the timer runs discards the count in progress and restarts the full duration from that edge.
- R11: The cause bit is write-1-to-clear. Writing 0 to it has no effect. An expiry on the same edge as a clear leaves the bit set.
- R12: `rd_data_o` shows the register selected by `rd_addr_i` one clock edge later. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Timer interrupt request (cause AND enable) |

## Verification
The main function is tried with several durations: 3 and 4 in one-shot mode, 2 and 1 in loop mode, and 0 in loop mode. The 0 case tells the tick-count rule apart from an off-by-one reload. Each expiry is sampled in the cycle before and the cycle after its expected edge, so a timer that is early or late by one cycle fails. A second start two milliseconds into a run is placed off the tick phase, which exposes a prescaler that is not restarted. A clear write aimed at the exact edge of a loop expiry tells "set wins" apart from "clear wins". Runs with the enable low, or with loop cleared in flight, show whether the cause bit and the halting behave as the requirements state.

// File: rtl/mstmr_pkg.sv
package mstmr_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_DUR   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CAUSE = 2'd2;

  localparam int B_START = 0;
  localparam int B_LOOP  = 1;
  localparam int B_IEN   = 2;

  typedef struct packed {
    logic irq_en;
    logic loop_en;
  } ctrl_t;
endpackage

// File: rtl/mstmr_prescaler.sv
module mstmr_prescaler #(
  parameter int CYC_PER_MS = 100000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  generate
    if (CYC_PER_MS <= 1) begin : g_direct
      assign tick_o = run_i && !restart_i;
    end else begin : g_div
      localparam int PW = $clog2(CYC_PER_MS);
      localparam logic [PW-1:0] LAST = PW'(CYC_PER_MS - 1);
      logic [PW-1:0] phase_q;

      assign tick_o = run_i && !restart_i && (phase_q == LAST);

      always_ff @(posedge clk_i) begin
        if (rst_i || restart_i || !run_i) begin
          phase_q <= '0;
        end else if (phase_q == LAST) begin
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + PW'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mstmr_countdown.sv
module mstmr_countdown #(
  parameter int DUR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             loop_i,
  input  logic             tick_i,
  output logic             running_o,
  output logic             expire_o,
  output logic [DUR_W-1:0] count_o
);
  logic [DUR_W-1:0] cnt_q;
  logic             run_q;
  logic             at_end;

  assign at_end    = (cnt_q <= DUR_W'(1));
  assign expire_o  = run_q && tick_i && !start_i && at_end;
  assign running_o = run_q;
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= dur_i;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      if (at_end) begin
        if (loop_i) begin
          cnt_q <= dur_i;
        end else begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - DUR_W'(1);
      end
    end
  end
endmodule

// File: rtl/mstmr_regs.sv
module mstmr_regs
  import mstmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DUR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              expire_i,
  output logic              start_o,
  output logic [DUR_W-1:0]  dur_o,
  output ctrl_t             ctrl_o,
  output logic              cause_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rd_data_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [DUR_W-1:0] dur_q;
  logic             cause_q, cause_d;
  logic             irq_q;
  logic [DATA_W-1:0] rd_q;
  logic             wr_ctrl, wr_dur, clr_cause;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_dur    = wr_en_i && (wr_addr_i == A_DUR);
  assign clr_cause = wr_en_i && (wr_addr_i == A_CAUSE) && wr_data_i[0];
  assign start_o   = wr_ctrl && wr_data_i[B_START];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.loop_en = wr_data_i[B_LOOP];
      ctrl_d.irq_en  = wr_data_i[B_IEN];
    end
    cause_d = (cause_q && !clr_cause) || (expire_i && ctrl_q.irq_en);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q  <= '0;
      dur_q   <= '0;
      cause_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      cause_q <= cause_d;
      irq_q   <= cause_d && ctrl_d.irq_en;
      if (wr_dur) dur_q <= wr_data_i[DUR_W-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_q <= '0;
    end else begin
      rd_q <= '0;
      case (rd_addr_i)
        A_CTRL: begin
          rd_q[B_LOOP] <= ctrl_q.loop_en;
          rd_q[B_IEN]  <= ctrl_q.irq_en;
        end
        A_DUR:   rd_q[DUR_W-1:0] <= dur_q;
        A_CAUSE: rd_q[0] <= cause_q;
        default: rd_q <= '0;
      endcase
    end
  end

  assign dur_o     = dur_q;
  assign ctrl_o    = ctrl_q;
  assign cause_o   = cause_q;
  assign irq_o     = irq_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/ms_period_timer.sv
module ms_period_timer
  import mstmr_pkg::*;
#(
  parameter int CYC_PER_MS = 100000,
  parameter int DUR_W      = 16,
  parameter int DATA_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic             start;
  logic [DUR_W-1:0] dur;
  ctrl_t            ctrl;
  logic             cause;
  logic             running;
  logic             tick;
  logic             expire;
  logic [DUR_W-1:0] count;

  mstmr_regs #(.DATA_W(DATA_W), .DUR_W(DUR_W)) regs_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .expire_i(expire),
    .start_o(start), .dur_o(dur), .ctrl_o(ctrl), .cause_o(cause),
    .irq_o(irq_o), .rd_data_o(rd_data_o)
  );

  mstmr_prescaler #(.CYC_PER_MS(CYC_PER_MS)) pre_i (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(running),
    .restart_i(start), .tick_o(tick)
  );

  mstmr_countdown #(.DUR_W(DUR_W)) cnt_i (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start), .dur_i(dur),
    .loop_i(ctrl.loop_en), .tick_i(tick), .running_o(running),
    .expire_o(expire), .count_o(count)
  );
endmodule

// File: rtl/mstmr_checker.sv
module mstmr_checker #(
  parameter int DUR_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             start,
  input logic             tick,
  input logic             expire,
  input logic             loop_en,
  input logic             irq_en,
  input logic             running,
  input logic [DUR_W-1:0] count,
  input logic [DUR_W-1:0] dur,
  input logic             cause,
  input logic             irq_o
);
  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (rst_i)
    start |=> (running && count == $past(dur))); // R2
  AST_TICK_ONLY_RUNNING: assert property (@(posedge clk_i) disable iff (rst_i)
    tick |-> running); // R3
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick && !start && count > DUR_W'(1)) |=> count == $past(count) - DUR_W'(1)); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick && !start) |=> $stable(count)); // R3
  AST_CAUSE_SET: assert property (@(posedge clk_i) disable iff (rst_i)
    (expire && irq_en) |=> cause); // R4
  AST_ONESHOT_HALT: assert property (@(posedge clk_i) disable iff (rst_i)
    (expire && !loop_en && !start) |=> !running); // R5
  AST_LOOP_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    (expire && loop_en && !start) |=> (running && count == $past(dur))); // R6
  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> (cause && irq_en)); // R8
endmodule

bind ms_period_timer mstmr_checker #(.DUR_W(DUR_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .start(start), .tick(tick),
  .expire(expire), .loop_en(ctrl.loop_en), .irq_en(ctrl.irq_en),
  .running(running), .count(count), .dur(dur), .cause(cause),
  .irq_o(irq_o)
);

// File: tb/ms_period_timer_tb_top.sv
module ms_period_timer_tb_top;
  localparam int P  = 8;
  localparam int DW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  ms_period_timer #(.CYC_PER_MS(P), .DUR_W(DW), .DATA_W(32)) dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; the write is taken at the next posedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq after reset", irq, 0);
    rd(2'd0, v); chk("R1 ctrl reset", v, 0);
    rd(2'd1, v); chk("R1 duration reset", v, 0);
    rd(2'd2, v); chk("R1 cause reset", v, 0);
    idle(40);
    chk("R1 no expiry unstarted", irq, 0);
    wr(2'd1, 32'd5);
    rd(2'd1, v); chk("R12 duration readback", v, 5);
    rd(2'd3, v); chk("R12 unused address", v, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(2'd1, 32'd3);
    wr(2'd0, 32'h5);
    idle(3*P - 1); chk("R3 no expiry one cycle early", irq, 0);
    idle(1);       chk("R3 expiry at D ms", irq, 1);
    rd(2'd2, v);   chk("R4 cause set", v, 1);
    rd(2'd0, v);   chk("R2 start bit reads 0", v, 32'h4);
    idle(50);      chk("R4 cause sticky", irq, 1);
    wr(2'd2, 32'd0); chk("R11 write 0 no effect", irq, 1);
    wr(2'd2, 32'd1); chk("R11 clear", irq, 0);
    idle(40);      chk("R5 one-shot halted", irq, 0);
  endtask

  task automatic t_loop();
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h7);
    idle(15); chk("R6 first period early", irq, 0);
    idle(1);  chk("R6 first expiry", irq, 1);
    wr(2'd2, 32'd1); chk("R11 clear in loop", irq, 0);
    idle(14); chk("R6 second period early", irq, 0);
    idle(1);  chk("R6 reload expiry", irq, 1);
    wr(2'd2, 32'd1);
    wr(2'd0, 32'h4);
    idle(13); chk("R6 before last expiry", irq, 0);
    idle(1);  chk("R6 last expiry after loop cleared", irq, 1);
    wr(2'd2, 32'd1);
    idle(40); chk("R6 stops when loop cleared", irq, 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h7);
    idle(P - 1); chk("R9 zero early", irq, 0);
    idle(1);     chk("R9 zero first tick", irq, 1);
    wr(2'd2, 32'd1);
    idle(P - 2); chk("R9 between ticks", irq, 0);
    idle(1);     chk("R9 zero every tick", irq, 1);
    wr(2'd0, 32'h0); chk("R8 enable off masks irq", irq, 0);
    rd(2'd2, v); chk("R8 cause kept while masked", v, 1);
    wr(2'd2, 32'd1);
    idle(20);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h1);
    idle(2*P + 5); chk("R7 disabled irq", irq, 0);
    rd(2'd2, v);   chk("R7 disabled no cause", v, 0);
    wr(2'd0, 32'h4);
    idle(30);      chk("R7 late enable no event", irq, 0);
  endtask

  task automatic t_restart();
    wr(2'd1, 32'd4);
    wr(2'd0, 32'h5);
    idle(16);
    wr(2'd0, 32'h5);
    idle(15); chk("R10 old deadline discarded", irq, 0);
    idle(16); chk("R10 prescaler restarted", irq, 0);
    idle(1);  chk("R10 full duration after restart", irq, 1);
    wr(2'd2, 32'd1);
    idle(5);
  endtask

  task automatic t_collide();
    wr(2'd1, 32'd1);
    wr(2'd0, 32'h7);
    idle(P);  chk("R6 one ms loop", irq, 1);
    idle(P - 1);
    wr(2'd2, 32'd1); chk("R11 set wins over clear", irq, 1);
    wr(2'd2, 32'd1); chk("R11 clear after collision", irq, 0);
    wr(2'd0, 32'h4);
    idle(20);
    wr(2'd2, 32'd1);
    chk("R11 final clear", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_loop();
    t_zero();
    t_disabled();
    t_restart();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule